// File: doc/BRIEF.md
# Per-Page Bus Response Auto-Detector

This block sits on a card attached to a shared memory bus covering a 1 MB address space split into sixteen 64 KB pages. For every read it decides whether the card should place its own byte on the bus or stay silent because memory on the motherboard already answers. Each page carries one of three modes: undecided, silent or driving. Silent and driving pages are answered at once. An undecided page triggers a probe. The block stretches the bus cycle with a wait request and keeps its data driver off. It then samples what the bus carries and compares that byte with the card's own copy.

A match means another device owns the page, so the page becomes silent. A mismatch means nobody answered, so the page becomes driving and the card drives its byte for the rest of the cycle. Once a page is decided it stays that way until reset. The length of the wait is set by a clock-count parameter. A read starts with a one-cycle strobe carrying the page index (address bits 19 to 16) and the card byte. It ends with a one-cycle done pulse, on which the data-enable shows the decision. Writes and data storage belong to neighbouring logic.

Top module: `page_resp_detect`

## Requirements
- R1: After reset, pages 0 to 9 are undecided, pages 10 to 14 are driving and page 15 is silent. The page is chosen by `rd_page`, which carries address bits [19:16].
- R2: While reset is held, and in the first cycle after it, `wait_req`, `drive_en` and `done` are all low.
- R3: A read of a driving page raises `done` together with `drive_en` in the cycle after the accepted strobe, with no wait cycles.
- R4: A read of a silent page raises `done` with `drive_en` low in the cycle after the strobe, with no wait cycles.
- R5: A read of an undecided page raises `wait_req` for exactly HOLD_CYCLES consecutive cycles, starting in the cycle after the strobe. `drive_en` stays low meanwhile. `done` follows one cycle after `wait_req` falls.
- R6: If `bus_byte`, sampled in the cycle after `wait_req` falls, equals the card byte captured with the strobe, then `done` comes with `drive_en` low and the page becomes silent.
- R7: If that sample differs from the card byte, then `done` comes with `drive_en` high and the page becomes driving.
- R8: A page that is silent or driving never returns to undecided and never changes again until reset. Later reads of it get no wait cycles, whatever the bus carries.
- R9: A strobe that arrives while a read is still in progress, including during the done cycle, is ignored and produces no extra `done`.
- R10: `done` lasts exactly one cycle, and `drive_en` is high only in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | One-cycle read strobe |
| rd_page | input | 4 | Page index, address bits [19:16], valid with the strobe |
| card_byte | input | 8 | Card's own byte for the read, captured with the strobe |
| bus_byte | input | 8 | Byte currently on the shared bus |
| wait_req | output | 1 | Wait request that stretches the bus cycle during a probe |
| drive_en | output | 1 | Card data driver enable |
| done | output | 1 | One-cycle pulse marking the end of a read |

## Verification
For a decided page, `done` is due exactly one cycle after the edge that accepts the strobe. For an undecided page, `wait_req` rises one cycle after that edge and stays high for HOLD_CYCLES cycles, and `done` follows two cycles after the last wait cycle: one cycle to sample the bus and one for the registered result. For every read, the driver task queues the expected decision and the expected number of wait cycles. The monitor counts wait cycles on falling edges and pops the queue on each `done`, so a wait that comes early, late or too long shows up as a count mismatch. A `done` that finds the queue empty is reported, and so is a queue left non-empty at the end.

// File: rtl/pgdet_pkg.sv
package pgdet_pkg;

  typedef enum logic [1:0] {
    PG_AUTO   = 2'd0,
    PG_SILENT = 2'd1,
    PG_DRIVE  = 2'd2
  } pg_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_HOLD   = 2'd1,
    SQ_SAMPLE = 2'd2,
    SQ_RESULT = 2'd3
  } sq_state_e;

  // Power-up mode of a page from its index and the two region limits.
  function automatic pg_mode_e reset_mode(input int unsigned page,
                                          input int unsigned auto_last,
                                          input int unsigned drive_last);
    if (page <= auto_last)       return PG_AUTO;
    else if (page <= drive_last) return PG_DRIVE;
    else                         return PG_SILENT;
  endfunction

  // Final mode of a probed page: a matching bus byte means another owner.
  function automatic pg_mode_e settle(input logic bus_matches);
    return bus_matches ? PG_SILENT : PG_DRIVE;
  endfunction

endpackage

// File: rtl/pgdet_table.sv
module pgdet_table #(
  parameter int unsigned NUM_PAGES  = 16,
  parameter int unsigned IDX_W      = 4,
  parameter int unsigned AUTO_LAST  = 9,
  parameter int unsigned DRIVE_LAST = 14
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [IDX_W-1:0]       lkp_idx,
  input  logic                   upd_en,
  input  logic [IDX_W-1:0]       upd_idx,
  input  pgdet_pkg::pg_mode_e    upd_mode,
  output pgdet_pkg::pg_mode_e    lkp_mode,
  output logic [2*NUM_PAGES-1:0] modes_flat
);
  import pgdet_pkg::*;

  pg_mode_e mode_r [NUM_PAGES];

  for (genvar gi = 0; gi < NUM_PAGES; gi++) begin : g_page
    // Only an undecided page accepts an update.
    always_ff @(posedge clk) begin
      if (!rst_n)
        mode_r[gi] <= reset_mode(gi, AUTO_LAST, DRIVE_LAST);
      else if (upd_en && (upd_idx == IDX_W'(gi)) && (mode_r[gi] == PG_AUTO))
        mode_r[gi] <= upd_mode;
    end
    assign modes_flat[2*gi +: 2] = mode_r[gi];
  end

  assign lkp_mode = mode_r[lkp_idx];

endmodule

// File: rtl/pgdet_timer.sv
module pgdet_timer #(
  parameter int unsigned HOLD_CYCLES = 40,
  localparam int unsigned CNT_W = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= CNT_W'(HOLD_CYCLES - 1);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/pgdet_seq.sv
module pgdet_seq #(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_req,
  input  logic [IDX_W-1:0]    rd_page,
  input  logic [DATA_W-1:0]   card_byte,
  input  logic [DATA_W-1:0]   bus_byte,
  input  pgdet_pkg::pg_mode_e cur_mode,
  input  logic                tmr_expired,
  output logic                tmr_load,
  output logic                upd_en,
  output logic [IDX_W-1:0]    upd_idx,
  output pgdet_pkg::pg_mode_e upd_mode,
  output logic                accept,
  output logic                wait_req,
  output logic                drive_en,
  output logic                done
);
  import pgdet_pkg::*;

  sq_state_e         state;
  logic [IDX_W-1:0]  page_q;
  logic [DATA_W-1:0] card_q;
  logic              drive_q;
  logic              bus_match;

  assign accept    = (state == SQ_IDLE) && rd_req;
  assign tmr_load  = accept && (cur_mode == PG_AUTO);
  assign bus_match = (bus_byte == card_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      page_q  <= '0;
      card_q  <= '0;
      drive_q <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: if (rd_req) begin
          page_q <= rd_page;
          card_q <= card_byte;
          case (cur_mode)
            PG_AUTO:  state <= SQ_HOLD;
            PG_DRIVE: begin drive_q <= 1'b1; state <= SQ_RESULT; end
            default:  begin drive_q <= 1'b0; state <= SQ_RESULT; end
          endcase
        end
        SQ_HOLD:   if (tmr_expired) state <= SQ_SAMPLE;
        SQ_SAMPLE: begin
          drive_q <= !bus_match;
          state   <= SQ_RESULT;
        end
        default:   state <= SQ_IDLE;
      endcase
    end
  end

  assign upd_en   = (state == SQ_SAMPLE);
  assign upd_idx  = page_q;
  assign upd_mode = settle(bus_match);
  assign wait_req = (state == SQ_HOLD);
  assign done     = (state == SQ_RESULT);
  assign drive_en = done && drive_q;

endmodule

// File: rtl/page_resp_detect.sv
module page_resp_detect #(
  parameter int unsigned NUM_PAGES   = 16,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned AUTO_LAST   = 9,
  parameter int unsigned DRIVE_LAST  = 14,
  parameter int unsigned HOLD_CYCLES = 40,
  localparam int unsigned IDX_W      = $clog2(NUM_PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [IDX_W-1:0]  rd_page,
  input  logic [DATA_W-1:0] card_byte,
  input  logic [DATA_W-1:0] bus_byte,
  output logic              wait_req,
  output logic              drive_en,
  output logic              done
);
  import pgdet_pkg::*;

  pg_mode_e               cur_mode;
  pg_mode_e               upd_mode;
  logic                   upd_en;
  logic [IDX_W-1:0]       upd_idx;
  logic                   tmr_load;
  logic                   tmr_expired;
  logic                   accept;
  logic [2*NUM_PAGES-1:0] modes_flat;

  pgdet_table #(
    .NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W),
    .AUTO_LAST(AUTO_LAST), .DRIVE_LAST(DRIVE_LAST)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .lkp_idx(rd_page),
    .upd_en(upd_en), .upd_idx(upd_idx), .upd_mode(upd_mode),
    .lkp_mode(cur_mode), .modes_flat(modes_flat)
  );

  pgdet_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .expired(tmr_expired)
  );

  pgdet_seq #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_page(rd_page),
    .card_byte(card_byte), .bus_byte(bus_byte), .cur_mode(cur_mode),
    .tmr_expired(tmr_expired), .tmr_load(tmr_load), .upd_en(upd_en),
    .upd_idx(upd_idx), .upd_mode(upd_mode), .accept(accept),
    .wait_req(wait_req), .drive_en(drive_en), .done(done)
  );

endmodule

// File: rtl/page_resp_detect_chk.sv
module page_resp_detect_chk #(
  parameter int unsigned NUM_PAGES = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   rd_req,
  input logic                   accept,
  input logic                   wait_req,
  input logic                   drive_en,
  input logic                   done,
  input logic [2*NUM_PAGES-1:0] modes_flat
);
  // R5: the data driver is never on while the cycle is stretched
  assert_no_drive_in_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wait_req |-> !drive_en);

  // R5: done follows one cycle after the wait request drops
  assert_done_after_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wait_req) |=> done);

  // R10: done is a single-cycle pulse
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: drive enable only during done
  assert_drive_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> done);

  // R9: a wait request only starts after an accepted strobe
  assert_wait_needs_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wait_req) |-> $past(accept) && $past(rd_req));

  // R8: a decided page keeps its mode
  for (genvar gi = 0; gi < NUM_PAGES; gi++) begin : g_keep
    assert_settled_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (modes_flat[2*gi +: 2] != 2'd0) |=> (modes_flat[2*gi +: 2] == $past(modes_flat[2*gi +: 2])));
  end

endmodule

bind page_resp_detect page_resp_detect_chk #(.NUM_PAGES(NUM_PAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .accept(accept),
  .wait_req(wait_req), .drive_en(drive_en), .done(done),
  .modes_flat(modes_flat)
);

// File: tb/page_resp_detect_bench.sv
module page_resp_detect_bench;
  localparam int HOLD = 40;

  typedef struct {
    logic  drv;
    int    waits;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_req = 1'b0;
  logic [3:0] rd_page = '0;
  logic [7:0] card_byte = '0;
  logic [7:0] bus_byte = '0;
  logic       wait_req, drive_en, done;

  int   total = 0;
  int   bad = 0;
  int   wcnt = 0;
  logic prev_done = 1'b0;
  exp_t sb[$];
  int   model[16];   // 0 undecided, 1 silent, 2 driving

  always #2.5 clk = ~clk;

  page_resp_detect #(.HOLD_CYCLES(HOLD)) u_page_resp_detect (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_page(rd_page),
    .card_byte(card_byte), .bus_byte(bus_byte),
    .wait_req(wait_req), .drive_en(drive_en), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: samples on falling edges, pops the scoreboard on each done.
  always @(negedge clk) begin
    if (rst_n) begin
      if (wait_req) wcnt++;
      if (drive_en && !done) check(1'b0, "R10 drive without done", 1, 0);
      if (done && prev_done) check(1'b0, "R10 done longer than one cycle", 2, 1);
      if (done) begin
        if (sb.size() == 0) begin
          check(1'b0, "R9 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(drive_en == e.drv, {e.tag, " drive_en"}, int'(drive_en), int'(e.drv));
          check(wcnt == e.waits, {e.tag, " wait cycles"}, wcnt, e.waits);
        end
        wcnt = 0;
      end
      prev_done = done;
    end
  end

  // Driver: issue one read, queue the expected result from the bench model.
  task automatic do_read(input logic [3:0] pg, input logic [7:0] cb,
                         input logic [7:0] bb, input string tag, input bit poke);
    exp_t e;
    e.tag = tag;
    if (model[pg] == 0) begin
      e.waits = HOLD;
      e.drv   = (bb != cb);
      model[pg] = (bb == cb) ? 1 : 2;
    end else begin
      e.waits = 0;
      e.drv   = (model[pg] == 2);
    end
    sb.push_back(e);
    @(negedge clk);
    rd_page = pg; card_byte = cb; bus_byte = bb; rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      rd_page = 4'hA; rd_req = 1'b1;       // R9: strobe during the hold
      @(negedge clk);
      rd_req = 1'b0; rd_page = pg;
    end
    while (!done) @(negedge clk);
    if (poke) begin
      rd_page = 4'hB; rd_req = 1'b1;       // R9: strobe during the done cycle
    end
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) model[i] = (i <= 9) ? 0 : ((i <= 14) ? 2 : 1);
    repeat (3) @(negedge clk);
    check(!wait_req && !drive_en && !done, "R2 outputs in reset",
          int'({wait_req, drive_en, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!wait_req && !drive_en && !done, "R2 outputs after reset",
          int'({wait_req, drive_en, done}), 0);

    do_read(4'hA, 8'h11, 8'h22, "R1 R3 page A drives", 1'b0);
    do_read(4'hE, 8'h33, 8'h33, "R1 R3 page E drives", 1'b0);
    do_read(4'hF, 8'h44, 8'h55, "R1 R4 page F silent", 1'b0);
    do_read(4'h0, 8'h5A, 8'h5A, "R5 R6 page 0 probe match", 1'b0);
    do_read(4'h0, 8'h5A, 8'hA5, "R8 R4 page 0 stays silent", 1'b0);
    do_read(4'h3, 8'hC3, 8'h3C, "R5 R7 page 3 probe differs", 1'b0);
    do_read(4'h3, 8'h77, 8'h77, "R8 R3 page 3 stays driving", 1'b0);
    do_read(4'h9, 8'h01, 8'h00, "R5 R7 R9 page 9 probe with stray strobes", 1'b0 == 1'b1 ? 1'b0 : 1'b1);
    do_read(4'h9, 8'h00, 8'h00, "R8 page 9 stays driving", 1'b0);
    do_read(4'h5, 8'hFF, 8'hFF, "R6 page 5 probe match", 1'b0);
    do_read(4'h5, 8'h12, 8'h34, "R8 page 5 stays silent", 1'b0);

    repeat (HOLD + 10) @(negedge clk);
    check(sb.size() == 0, "R9 scoreboard drained", sb.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    check(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule